// File: doc/BRIEF.md
# Two-Rate Transition Line Coder and Decoder

This block carries fixed-length words across a single wire between two sections of logic that run on unrelated clocks. The transmit half sends every bit in a slot of two transmit-clock cycles. It always toggles the line at the start of a slot. For a one it toggles again in the middle of the slot. Between words the line keeps toggling once per slot, so idle looks exactly like a run of zeros. A one-valued start bit opens each frame, and the payload follows most significant bit first.

The receive half needs no phase-locked loop. It passes the line through a two-flop synchronizer and counts receive-clock cycles between transitions. Each gap is then classed as short (half of a one) or long (a whole zero). Only the spacing of transitions carries information, so an inverted line decodes the same. Both halves present a parallel word with a valid/ready handshake.

Top module: `fm_link`

## Requirements
- R1: While reset is held and in the first cycle after it, `line_out`, `tx_ready`, `rx_valid` and `rx_code_err` are all low.
- R2: With no word offered, `line_out` toggles exactly once every two transmit cycles.
- R3: `tx_ready` is high only in the second cycle of a slot, and only when the transmitter is idle or is sending the final payload bit. A word is taken when `tx_valid` and `tx_ready` are both high at a clock edge, and `tx_ready` is low in the next cycle.
- R4: A frame is a start bit of 1 followed by `WORD_W` payload bits, MSB first. A 1 toggles the line at the start and at the middle of its slot. A 0 toggles it at the start only.
- R5: A word offered during the final slot of a frame is accepted there. Its start bit follows with no idle slot, so successive acceptances are exactly 2*(WORD_W+1) transmit cycles apart.
- R6: The receiver outputs each transmitted word on `rx_data` with `rx_valid` high. Gaps shorter than 1.5*OSR receive cycles count as half of a one, and longer gaps count as a zero.
- R7: Inverting the line between the two halves does not change the decoded words.
- R8: Words decode correctly when the receive clock is up to about 20% faster or slower than OSR times the transmit clock.
- R9: `rx_valid` stays high with `rx_data` unchanged until `rx_ready` is high. A later word replaces an untaken one.
- R10: A short gap followed by a long gap raises `rx_code_err` for one cycle. The partial word is discarded, and the receiver looks for a new start bit.
- R11: Idle zeros outside a frame produce no output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Transmit clock, one unit interval per cycle |
| rst_tx_n | input | 1 | Asynchronous active-low reset, transmit side |
| tx_data | input | WORD_W | Word to send |
| tx_valid | input | 1 | Word on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter takes the offered word at this edge |
| line_out | output | 1 | Coded serial line |
| clk_rx | input | 1 | Free-running receive clock |
| rst_rx_n | input | 1 | Asynchronous active-low reset, receive side |
| line_in | input | 1 | Serial line into the receiver, either polarity |
| rx_data | output | WORD_W | Decoded word |
| rx_valid | output | 1 | `rx_data` holds an untaken word |
| rx_ready | input | 1 | Consumer takes the word |
| rx_code_err | output | 1 | One-cycle pulse on a malformed one |

## Verification
The bench uses the defaults: WORD_W=16 and OSR=4. With these values the short/long threshold is 6 receive cycles, and a frame lasts 34 transmit cycles. Receive periods of 4.2 ns and 6.0 ns against a 20 ns transmit clock then push nominal gaps of 4 and 8 counts close to that threshold. This tests the quantization margin on both sides in short runs. The bench also drives a hand-built line carrying an isolated half-one, to check the code-error path and that a clean frame which follows still decodes.

// File: rtl/fm_link.sv
module fm_link #(
  parameter int WORD_W = 16,
  parameter int OSR    = 4
) (
  input  logic              clk_tx,
  input  logic              rst_tx_n,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              line_out,
  input  logic              clk_rx,
  input  logic              rst_rx_n,
  input  logic              line_in,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_code_err
);
  localparam int SLOT_W    = $clog2(WORD_W + 1);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int SHORT_LIM = (3 * OSR) / 2;
  localparam int GAP_MAX   = 4 * OSR;
  localparam int GAP_W     = $clog2(GAP_MAX + 1);

  // transmit side
  logic              half_q, busy_q, line_q;
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W:0]   sh_q;

  wire last_slot = busy_q && (slot_q == SLOT_W'(WORD_W));
  wire cur_one   = busy_q && sh_q[WORD_W];
  assign tx_ready = half_q && (!busy_q || last_slot);
  assign line_out = line_q;

  always_ff @(posedge clk_tx or negedge rst_tx_n) begin
    if (!rst_tx_n) begin
      half_q <= 1'b0;
      busy_q <= 1'b0;
      line_q <= 1'b0;
      slot_q <= '0;
      sh_q   <= '0;
    end else begin
      half_q <= ~half_q;
      if (!half_q) begin
        if (cur_one) line_q <= ~line_q;
      end else begin
        line_q <= ~line_q;
        if (tx_valid && tx_ready) begin
          busy_q <= 1'b1;
          sh_q   <= {1'b1, tx_data};
          slot_q <= '0;
        end else if (last_slot) begin
          busy_q <= 1'b0;
        end else if (busy_q) begin
          sh_q   <= {sh_q[WORD_W-1:0], 1'b0};
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  // receive side
  logic [2:0]        sync_q;
  logic              started_q, armed_q, pend_q, in_frame_q;
  logic [GAP_W-1:0]  gap_q;
  logic [BIT_W-1:0]  nbit_q;
  logic [WORD_W-1:0] acc_q;

  wire edge_seen = sync_q[2] ^ sync_q[1];
  wire is_short  = gap_q < GAP_W'(SHORT_LIM);
  wire judge     = edge_seen && armed_q;
  wire bit_done  = judge && (is_short ? pend_q : !pend_q);
  wire bad       = judge && !is_short && pend_q;
  wire word_done = bit_done && in_frame_q && (nbit_q == BIT_W'(WORD_W - 1));
  wire [WORD_W-1:0] next_acc = {acc_q[WORD_W-2:0], is_short};

  always_ff @(posedge clk_rx or negedge rst_rx_n) begin
    if (!rst_rx_n) begin
      sync_q      <= '0;
      started_q   <= 1'b0;
      armed_q     <= 1'b0;
      pend_q      <= 1'b0;
      in_frame_q  <= 1'b0;
      gap_q       <= '0;
      nbit_q      <= '0;
      acc_q       <= '0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_code_err <= 1'b0;
    end else begin
      sync_q      <= {sync_q[1:0], line_in};
      rx_code_err <= bad;
      if (edge_seen) begin
        started_q <= 1'b1;
        gap_q     <= GAP_W'(1);
        if (started_q && !is_short) armed_q <= 1'b1;
      end else if (gap_q != GAP_W'(GAP_MAX)) begin
        gap_q <= gap_q + 1'b1;
      end
      if (judge) pend_q <= is_short && !pend_q;
      if (bad) begin
        in_frame_q <= 1'b0;
      end else if (bit_done) begin
        if (!in_frame_q) begin
          if (is_short) begin
            in_frame_q <= 1'b1;
            nbit_q     <= '0;
          end
        end else begin
          acc_q  <= next_acc;
          nbit_q <= nbit_q + 1'b1;
          if (word_done) in_frame_q <= 1'b0;
        end
      end
      if (word_done) begin
        rx_data  <= next_acc;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fm_link_chk.sv
module fm_link_chk (
  input logic clk_tx,
  input logic rst_tx_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic line_out,
  input logic clk_rx,
  input logic rst_rx_n,
  input logic rx_valid,
  input logic rx_ready,
  input logic rx_code_err
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_tx or negedge rst_tx_n) begin
    if (!rst_tx_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
  end

  // R2
  line_moves_chk: assert property (@(posedge clk_tx) disable iff (!rst_tx_n)
    (warm_q == 2'd3) |-> !(line_out == $past(line_out) && line_out == $past(line_out, 2)));

  // R3
  ready_drop_chk: assert property (@(posedge clk_tx) disable iff (!rst_tx_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R9
  rx_hold_chk: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R10
  word_vs_err_chk: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    $rose(rx_valid) |-> !rx_code_err);
endmodule

bind fm_link fm_link_chk u_chk (.*);

// File: tb/tb_fm_link.sv
`timescale 1ns/1ps
module tb_fm_link;
  localparam int W   = 16;
  localparam int OSR = 4;
  localparam int FRAME_CYC = 2 * (W + 1);

  logic clk_tx = 0, clk_rx = 0;
  logic rst_tx_n = 0, rst_rx_n = 0;
  logic [W-1:0] tx_data = '0;
  logic tx_valid = 0, rx_ready = 1;
  logic man_sel = 0, man_line = 0, inv_sel = 0;
  wire  tx_ready, line_out, rx_valid, rx_code_err;
  wire  [W-1:0] rx_data;
  wire  line_in = man_sel ? man_line : (line_out ^ inv_sel);
  real  rx_half = 2.5;

  int checks = 0, errs = 0, err_pulses = 0, tx_cyc = 0, last_acc = -1, acc_gap = 0;
  logic [W-1:0] exp_w[$];

  always #10 clk_tx = ~clk_tx;
  always #(rx_half) clk_rx = ~clk_rx;

  fm_link #(.WORD_W(W), .OSR(OSR)) dut (
    .clk_tx(clk_tx), .rst_tx_n(rst_tx_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .line_out(line_out),
    .clk_rx(clk_rx), .rst_rx_n(rst_rx_n), .line_in(line_in), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_code_err(rx_code_err));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // behavioural line model, one step per transmit cycle
  int  m_ph;
  bit  m_line, m_cur, exp_rdy;
  bit  m_q[$];
  always @(negedge clk_tx) begin
    if (!rst_tx_n) begin
      m_ph = 0; m_line = 0; m_cur = 0; m_q.delete();
    end else begin
      tx_cyc++;
      exp_rdy = (m_ph == 1) && (m_q.size() == 0);
      chk(line_out == m_line, "R4", "line level", 32'(line_out), 32'(m_line));
      chk(tx_ready == exp_rdy, "R3", "tx_ready", 32'(tx_ready), 32'(exp_rdy));
      if (m_ph == 0) begin
        if (m_cur) m_line = ~m_line;
        m_ph = 1;
      end else begin
        m_line = ~m_line;
        m_ph = 0;
        if (tx_valid && tx_ready) begin
          m_q.push_back(1'b1);
          for (int i = W - 1; i >= 0; i--) m_q.push_back(tx_data[i]);
          if (!man_sel) exp_w.push_back(tx_data);
          if (last_acc >= 0) acc_gap = tx_cyc - last_acc;
          last_acc = tx_cyc;
        end
        m_cur = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
      end
    end
  end

  // receive monitor
  always @(negedge clk_rx) begin
    if (rst_rx_n) begin
      if (rx_code_err) err_pulses++;
      if (rx_valid && rx_ready) begin
        if (exp_w.size() == 0) begin
          chk(1'b0, "R11", "word with nothing sent", 32'(rx_data), 32'h0);
        end else begin
          logic [W-1:0] e;
          e = exp_w.pop_front();
          chk(rx_data == e, "R6", "decoded word", 32'(rx_data), 32'(e));
        end
      end
    end
  end

  task automatic send_word(input logic [W-1:0] w);
    @(posedge clk_tx); #2;
    tx_valid = 1; tx_data = w;
    do @(negedge clk_tx); while (!tx_ready);
    @(posedge clk_tx); #2;
    tx_valid = 0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_w.size() != 0 && n < 4000) begin @(negedge clk_rx); n++; end
    chk(exp_w.size() == 0, req, "words outstanding", 32'(exp_w.size()), 32'h0);
  endtask

  task automatic rx_restart(input real half, input bit man, input bit inv);
    @(posedge clk_rx); #1;
    rst_rx_n = 0;
    repeat (4) @(posedge clk_rx);
    rx_half = half; man_sel = man; inv_sel = inv; man_line = 0;
    repeat (4) @(posedge clk_rx);
    #1 rst_rx_n = 1;
    repeat (4 * OSR * 3) @(posedge clk_rx);
  endtask

  task automatic m_wait(input int n);
    repeat (n) @(posedge clk_rx);
    #1;
  endtask

  task automatic m_bit(input bit b);
    man_line = ~man_line; m_wait(OSR);
    if (b) man_line = ~man_line;
    m_wait(OSR);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "R6", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    int toggles;
    logic prev;
    // R1 reset state
    repeat (3) @(negedge clk_tx);
    chk(line_out == 0, "R1", "line in reset", 32'(line_out), 32'h0);
    chk(tx_ready == 0, "R1", "tx_ready in reset", 32'(tx_ready), 32'h0);
    chk(rx_valid == 0, "R1", "rx_valid in reset", 32'(rx_valid), 32'h0);
    chk(rx_code_err == 0, "R1", "code error in reset", 32'(rx_code_err), 32'h0);
    @(posedge clk_tx); #2;
    rst_tx_n = 1; rst_rx_n = 1;
    @(negedge clk_tx);
    chk(line_out == 0 && tx_ready == 0, "R1", "first cycle after reset",
        {30'h0, line_out, tx_ready}, 32'h0);

    // R2 idle toggle rate
    repeat (10) @(negedge clk_tx);
    toggles = 0; prev = line_out;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_tx);
      if (line_out != prev) toggles++;
      prev = line_out;
    end
    chk(toggles == 10, "R2", "idle toggles in 20 cycles", 32'(toggles), 32'd10);

    // R4 R6 single frames
    send_word(16'hA5C3); drain("R6");
    send_word(16'h0000); drain("R6");
    send_word(16'hFFFF); drain("R6");
    send_word(16'h8001); drain("R4");

    // R5 back-to-back
    send_word(16'h1234);
    send_word(16'hFEDC);
    chk(acc_gap == FRAME_CYC, "R5", "cycles between acceptances", 32'(acc_gap), 32'(FRAME_CYC));
    drain("R5");

    // R9 hold until taken
    @(posedge clk_rx); #1 rx_ready = 0;
    send_word(16'h3C5A);
    begin
      int n = 0;
      while (!rx_valid && n < 4000) begin @(negedge clk_rx); n++; end
    end
    repeat (10) @(negedge clk_rx);
    chk(rx_valid == 1, "R9", "valid held", 32'(rx_valid), 32'h1);
    chk(rx_data == 16'h3C5A, "R9", "data held", 32'(rx_data), 32'h3C5A);
    @(posedge clk_rx); #1 rx_ready = 1;
    drain("R9");
    @(negedge clk_rx); @(negedge clk_rx);
    chk(rx_valid == 0, "R9", "valid drops once taken", 32'(rx_valid), 32'h0);

    // R7 inverted line
    rx_restart(2.5, 0, 1);
    send_word(16'hC0DE); send_word(16'h5A5A); drain("R7");

    // R8 receive clock faster and slower
    rx_restart(2.1, 0, 0);
    send_word(16'hB00F); send_word(16'h7E81); drain("R8");
    rx_restart(3.0, 0, 0);
    send_word(16'h6D29); send_word(16'hF00D); drain("R8");
    rx_restart(2.5, 0, 0);

    // R10 malformed one, then a clean frame
    rx_restart(2.5, 1, 0);
    for (int i = 0; i < 4; i++) m_bit(0);
    m_bit(1); m_bit(1); m_bit(0); m_bit(1);
    man_line = ~man_line; m_wait(OSR);
    man_line = ~man_line; m_wait(2 * OSR);
    for (int i = 0; i < 4; i++) m_bit(0);
    chk(err_pulses == 1, "R10", "code error pulses", 32'(err_pulses), 32'h1);
    chk(rx_valid == 0, "R10", "partial word dropped", 32'(rx_valid), 32'h0);
    exp_w.push_back(16'h9E21);
    m_bit(1);
    for (int i = W - 1; i >= 0; i--) m_bit(W'(16'h9E21) >> i);
    for (int i = 0; i < 3; i++) m_bit(0);
    drain("R10");
    chk(err_pulses == 1, "R10", "no further errors", 32'(err_pulses), 32'h1);

    // R11 long idle yields nothing
    rx_restart(2.5, 0, 0);
    repeat (200) @(negedge clk_tx);
    chk(exp_w.size() == 0 && !rx_valid, "R11", "idle output", 32'(rx_valid), 32'h0);
    finish_run();
  end
endmodule